// File: doc/BRIEF.md
# PC-Relative Memory-Indirect Postindexed Address Generator

This block produces the effective address for an addressing mode in which a pointer is first fetched from memory and only then offset. When a start request arrives for the matching mode and register fields, the block captures its operands. It adds a sign-extended base displacement to the program counter, which is the address of the first extension word, or to zero when the zero-PC control is set. The result is an intermediate address. The block issues one 32-bit read at that address and marks it as a read-only access to program space.

When the read is acknowledged, the returned long word becomes the pointer. The block adds a scaled index to this pointer, along with a sign-extended outer displacement. The final sum is presented for one cycle together with a done pulse. All arithmetic wraps modulo 2^32. The sequence runs through four states in order: idle, fetch, add, done.

Top module: `pcmi_agen`

## Requirements
- R1: While a read is requested, `mem_addr_o` equals the sign-extended base displacement plus `pc_i`. When `zpc_i` is 1, zero is used in place of `pc_i`.
- R2: Each displacement has a 2-bit size code: 00 = null (zero), 01 = word (bits 15:0 sign-extended to 32 bits), 10 = long (all 32 bits), 11 = null (zero).
- R3: The index is bits 15:0 sign-extended when `idx_long_i` is 0, and all 32 bits when it is 1. It is then shifted left by `idx_scale_i` (0 to 3), which multiplies it by 1, 2, 4 or 8. When `idx_sup_i` is 1, the index contributes zero.
- R4: `ea_o` equals the fetched long word plus the scaled index plus the outer displacement, modulo 2^32, with no overflow indication.
- R5: Whenever `mem_req_o` is 1, `mem_prog_o` and `mem_rd_o` are both 1. When no request is active, both are 0.
- R6: Once raised, `mem_req_o` stays high with a stable `mem_addr_o` until a cycle in which `mem_ack_i` is 1. After that cycle it drops.
- R7: `done_o` is high for exactly one cycle, two clock edges after the edge that accepts the acknowledge. `ea_o` is valid while `done_o` is high.
- R8: `start_i` is accepted only when the block is idle, `mode_i` is 3'b111 and `reg_i` is 3'b011. In every other case `start_i` is ignored.
- R9: After reset, `mem_req_o`, `mem_prog_o`, `mem_rd_o` and `done_o` are 0.
- R10: Operands are captured when the start is accepted. Later changes on the operand inputs do not affect the current computation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request |
| mode_i | input | 3 | Addressing mode field |
| reg_i | input | 3 | Register field |
| pc_i | input | 32 | Address of the first extension word |
| zpc_i | input | 1 | Replace the PC with zero |
| bd_i | input | 32 | Base displacement, raw |
| bd_sz_i | input | 2 | Base displacement size code |
| od_i | input | 32 | Outer displacement, raw |
| od_sz_i | input | 2 | Outer displacement size code |
| idx_i | input | 32 | Index register value |
| idx_long_i | input | 1 | Index size: 0 word, 1 long |
| idx_scale_i | input | 2 | Index scale as a left-shift count |
| idx_sup_i | input | 1 | Suppress the index |
| mem_req_o | output | 1 | Memory read request |
| mem_addr_o | output | 32 | Intermediate indirect address |
| mem_prog_o | output | 1 | Program-space qualifier |
| mem_rd_o | output | 1 | Read-only qualifier |
| mem_ack_i | input | 1 | Memory acknowledge |
| mem_rdata_i | input | 32 | Fetched long word |
| done_o | output | 1 | Effective address valid, one cycle |
| ea_o | output | 32 | Effective address |

## Verification
The assertions check the handshake on every cycle. They cover the qualifiers that must accompany the request, and the request held with a steady address until the acknowledge. They also cover the fixed ack-to-done distance, the single-cycle done pulse, and the rejection of a start that arrives with the wrong fields. The arithmetic cannot be seen by the assertions and is shown only by the bench's scenarios. This covers sign extension per size code, index scaling and suppression, the zero-PC substitution, wraparound, and the capture of operands at start. For these the bench compares the intermediate and effective addresses against values it computes itself.

// File: rtl/pcmi_pkg.sv
package pcmi_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_ADD   = 2'd2,
    ST_DONE  = 2'd3
  } state_e;

  localparam logic [1:0] SZ_NULL = 2'b00;
  localparam logic [1:0] SZ_WORD = 2'b01;
  localparam logic [1:0] SZ_LONG = 2'b10;
endpackage

// File: rtl/pcmi_disp_ext.sv
module pcmi_disp_ext #(
  parameter int unsigned AW = 32,
  parameter int unsigned HW = 16
) (
  input  logic [1:0]    sz_i,
  input  logic [AW-1:0] raw_i,
  output logic [AW-1:0] val_o
);
  import pcmi_pkg::*;
  localparam int unsigned EXT = AW - HW;

  always_comb begin
    case (sz_i)
      SZ_WORD: val_o = {{EXT{raw_i[HW-1]}}, raw_i[HW-1:0]};
      SZ_LONG: val_o = raw_i;
      default: val_o = '0; // null and reserved code
    endcase
  end
endmodule

// File: rtl/pcmi_index_scale.sv
module pcmi_index_scale #(
  parameter int unsigned AW = 32,
  parameter int unsigned HW = 16,
  parameter int unsigned SW = 2
) (
  input  logic [AW-1:0] idx_i,
  input  logic          long_i,
  input  logic [SW-1:0] scale_i,
  input  logic          sup_i,
  output logic [AW-1:0] val_o
);
  localparam int unsigned EXT = AW - HW;
  logic [AW-1:0] sized;

  always_comb begin
    sized = long_i ? idx_i : {{EXT{idx_i[HW-1]}}, idx_i[HW-1:0]};
    val_o = sup_i ? '0 : (sized << scale_i);
  end
endmodule

// File: rtl/pcmi_seq.sv
module pcmi_seq (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic               mode_ok_i,
  input  logic               ack_i,
  output pcmi_pkg::state_e   state_o,
  output logic               load_o,
  output logic               fetch_o,
  output logic               cap_o,
  output logic               add_o,
  output logic               done_o
);
  import pcmi_pkg::*;
  state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:  if (start_i && mode_ok_i) state_d = ST_FETCH;
      ST_FETCH: if (ack_i) state_d = ST_ADD;
      ST_ADD:   state_d = ST_DONE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign state_o = state_q;
  assign load_o  = (state_q == ST_IDLE) && start_i && mode_ok_i;
  assign fetch_o = (state_q == ST_FETCH);
  assign cap_o   = fetch_o && ack_i;
  assign add_o   = (state_q == ST_ADD);
  assign done_o  = (state_q == ST_DONE);
endmodule

// File: rtl/pcmi_agen.sv
module pcmi_agen #(
  parameter int unsigned AW       = 32,
  parameter int unsigned HW       = 16,
  parameter int unsigned SW       = 2,
  parameter logic [2:0]  MODE_SEL = 3'b111,
  parameter logic [2:0]  REG_SEL  = 3'b011
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [2:0]    mode_i,
  input  logic [2:0]    reg_i,
  input  logic [AW-1:0] pc_i,
  input  logic          zpc_i,
  input  logic [AW-1:0] bd_i,
  input  logic [1:0]    bd_sz_i,
  input  logic [AW-1:0] od_i,
  input  logic [1:0]    od_sz_i,
  input  logic [AW-1:0] idx_i,
  input  logic          idx_long_i,
  input  logic [SW-1:0] idx_scale_i,
  input  logic          idx_sup_i,
  output logic          mem_req_o,
  output logic [AW-1:0] mem_addr_o,
  output logic          mem_prog_o,
  output logic          mem_rd_o,
  input  logic          mem_ack_i,
  input  logic [AW-1:0] mem_rdata_i,
  output logic          done_o,
  output logic [AW-1:0] ea_o
);
  import pcmi_pkg::*;

  logic [AW-1:0] bd_ext, od_ext, idx_sc, base;
  logic [AW-1:0] inter_q, post_q, ptr_q, ea_q;
  logic          mode_ok, load, fetch, cap, add;
  state_e        state_q;

  assign mode_ok = (mode_i == MODE_SEL) && (reg_i == REG_SEL);
  assign base    = zpc_i ? '0 : pc_i;

  pcmi_disp_ext #(.AW(AW), .HW(HW)) u_bd (.sz_i(bd_sz_i), .raw_i(bd_i), .val_o(bd_ext));
  pcmi_disp_ext #(.AW(AW), .HW(HW)) u_od (.sz_i(od_sz_i), .raw_i(od_i), .val_o(od_ext));

  pcmi_index_scale #(.AW(AW), .HW(HW), .SW(SW)) u_idx (
    .idx_i(idx_i), .long_i(idx_long_i), .scale_i(idx_scale_i),
    .sup_i(idx_sup_i), .val_o(idx_sc)
  );

  pcmi_seq u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .mode_ok_i(mode_ok),
    .ack_i(mem_ack_i), .state_o(state_q), .load_o(load), .fetch_o(fetch),
    .cap_o(cap), .add_o(add), .done_o(done_o)
  );

  // post-index sum is operand-only, so it is folded at start
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      inter_q <= '0;
      post_q  <= '0;
      ptr_q   <= '0;
      ea_q    <= '0;
    end else begin
      if (load) begin
        inter_q <= base + bd_ext;
        post_q  <= idx_sc + od_ext;
      end
      if (cap) ptr_q <= mem_rdata_i;
      if (add) ea_q  <= ptr_q + post_q;
    end
  end

  assign mem_req_o  = fetch;
  assign mem_prog_o = fetch;
  assign mem_rd_o   = fetch;
  assign mem_addr_o = inter_q;
  assign ea_o       = ea_q;
endmodule

// File: rtl/pcmi_agen_chk.sv
module pcmi_agen_chk #(
  parameter int unsigned AW = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic [2:0]       mode_i,
  input logic [2:0]       reg_i,
  input pcmi_pkg::state_e state_i,
  input logic             mem_req_o,
  input logic [AW-1:0]    mem_addr_o,
  input logic             mem_prog_o,
  input logic             mem_rd_o,
  input logic             mem_ack_i,
  input logic             done_o
);
  import pcmi_pkg::*;

  assert_req_qualified_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> (mem_prog_o && mem_rd_o));

  assert_no_qual_idle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_req_o |-> (!mem_prog_o && !mem_rd_o));

  assert_req_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o)));

  assert_req_drop_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_ack_i) |=> !mem_req_o);

  assert_done_timing_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_ack_i) |=> ##1 done_o);

  assert_done_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_bad_start_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_IDLE && start_i && !(mode_i == 3'b111 && reg_i == 3'b011))
      |=> (state_i == ST_IDLE && !mem_req_o));

  assert_good_start_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_IDLE && start_i && mode_i == 3'b111 && reg_i == 3'b011)
      |=> mem_req_o);

  always_comb begin
    if (!rst_ni) begin
      assert_reset_quiet_R9: assert (!mem_req_o && !done_o);
    end
  end
endmodule

bind pcmi_agen pcmi_agen_chk #(.AW(AW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .mode_i(mode_i),
  .reg_i(reg_i), .state_i(state_q), .mem_req_o(mem_req_o),
  .mem_addr_o(mem_addr_o), .mem_prog_o(mem_prog_o), .mem_rd_o(mem_rd_o),
  .mem_ack_i(mem_ack_i), .done_o(done_o)
);

// File: tb/sim_pcmi_agen.sv
`timescale 1ns/1ps
module sim_pcmi_agen;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [2:0]  mode_i = 3'b111;
  logic [2:0]  reg_i = 3'b011;
  logic [31:0] pc_i = '0, bd_i = '0, od_i = '0, idx_i = '0, mem_rdata_i = '0;
  logic        zpc_i = 1'b0, idx_long_i = 1'b0, idx_sup_i = 1'b0, mem_ack_i = 1'b0;
  logic [1:0]  bd_sz_i = '0, od_sz_i = '0, idx_scale_i = '0;
  logic        mem_req_o, mem_prog_o, mem_rd_o, done_o;
  logic [31:0] mem_addr_o, ea_o;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  logic [31:0] exp_q[$];

  always #5 clk_i = ~clk_i;

  pcmi_agen u0 (.*);

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] dext(input logic [1:0] sz, input logic [31:0] v);
    if (sz == 2'b01) return {{16{v[15]}}, v[15:0]};
    if (sz == 2'b10) return v;
    return 32'h0;
  endfunction

  function automatic logic [31:0] iext(input logic [31:0] v, input bit lng, input logic [1:0] sc, input bit sup);
    logic [31:0] w;
    if (sup) return 32'h0;
    w = lng ? v : {{16{v[15]}}, v[15:0]};
    return w * (32'd1 << sc);
  endfunction

  // monitor: pops an expected EA on every done pulse
  always @(negedge clk_i) begin
    if (rst_ni && done_o) begin
      if (exp_q.size() == 0) chk(1'b0, "R8 unexpected done", ea_o, 32'h0);
      else begin
        logic [31:0] e;
        e = exp_q.pop_front();
        chk(ea_o == e, "R4 R7 effective address", ea_o, e);
      end
    end
  end

  task automatic run(input logic [31:0] pc, input bit zpc, input logic [31:0] bd, input logic [1:0] bsz,
                     input logic [31:0] idx, input bit lng, input logic [1:0] sc, input bit sup,
                     input logic [31:0] od, input logic [1:0] osz, input logic [31:0] rdata,
                     input int lat, input bit poke);
    logic [31:0] inter;
    inter = (zpc ? 32'h0 : pc) + dext(bsz, bd);
    exp_q.push_back(rdata + iext(idx, lng, sc, sup) + dext(osz, od));
    @(negedge clk_i);
    pc_i = pc; zpc_i = zpc; bd_i = bd; bd_sz_i = bsz; idx_i = idx; idx_long_i = lng;
    idx_scale_i = sc; idx_sup_i = sup; od_i = od; od_sz_i = osz; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    // R10: scramble operands after capture
    pc_i = 32'hDEAD_BEEF; bd_i = 32'h1357_9BDF; idx_i = 32'h7FFF_0001; od_i = 32'hCAFE_F00D;
    zpc_i = ~zpc; bd_sz_i = 2'b10; od_sz_i = 2'b10; idx_scale_i = 2'd3; idx_sup_i = ~sup;
    chk(mem_req_o, "R6 request raised", {31'h0, mem_req_o}, 32'h1);
    chk(mem_addr_o == inter, "R1 R2 R10 intermediate address", mem_addr_o, inter);
    chk(mem_prog_o && mem_rd_o, "R5 qualifiers", {30'h0, mem_prog_o, mem_rd_o}, 32'h3);
    for (int i = 0; i < lat; i++) begin
      if (poke) start_i = 1'b1;
      @(negedge clk_i);
      start_i = 1'b0;
      chk(mem_req_o && mem_addr_o == inter, "R6 R8 request held", mem_addr_o, inter);
    end
    mem_ack_i = 1'b1; mem_rdata_i = rdata;
    @(negedge clk_i);
    mem_ack_i = 1'b0; mem_rdata_i = 32'h0BAD_0BAD;
    chk(!mem_req_o, "R6 request dropped", {31'h0, mem_req_o}, 32'h0);
    @(negedge clk_i);
    chk(done_o, "R7 done timing", {31'h0, done_o}, 32'h1);
    @(negedge clk_i);
    chk(!done_o, "R7 done single cycle", {31'h0, done_o}, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    chk(!mem_req_o && !mem_prog_o && !mem_rd_o && !done_o, "R9 reset state",
        {28'h0, mem_req_o, mem_prog_o, mem_rd_o, done_o}, 32'h0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    run(32'h0000_1000, 0, 32'h0000_FFF0, 2'b01, 32'h0000_8000, 0, 2'd2, 0,
        32'h0000_0010, 2'b10, 32'h0020_0000, 0, 0);               // R2 R3 word negatives
    run(32'h4000_0000, 1, 32'h1234_5678, 2'b10, 32'h0000_0003, 1, 2'd1, 0,
        32'h0000_0000, 2'b00, 32'h0000_0100, 2, 0);               // R1 zero PC
    run(32'h0000_2000, 0, 32'hFFFF_FFFF, 2'b00, 32'hFFFF_FFFF, 1, 2'd3, 1,
        32'hFFFF_FFFF, 2'b00, 32'h8765_4321, 1, 1);               // R3 suppressed, R8 busy start
    run(32'hFFFF_FFF0, 0, 32'h0000_0020, 2'b01, 32'h8000_0000, 1, 2'd3, 0,
        32'h0000_0020, 2'b01, 32'hFFFF_FFF0, 3, 0);               // R4 wraparound
    run(32'h0000_3000, 0, 32'h0000_7FFF, 2'b11, 32'h1234_FFFE, 0, 2'd0, 0,
        32'h0000_8001, 2'b11, 32'h0001_0000, 0, 0);               // R2 reserved code null
    run(32'h0010_0000, 0, 32'h0000_8000, 2'b01, 32'hFFFF_FFFC, 1, 2'd1, 0,
        32'hFFFF_8000, 2'b10, 32'h0000_0040, 4, 0);               // R3 long negative index

    // R8: wrong mode or register field ignored
    @(negedge clk_i);
    mode_i = 3'b110; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    chk(!mem_req_o, "R8 wrong mode ignored", {31'h0, mem_req_o}, 32'h0);
    mode_i = 3'b111; reg_i = 3'b010; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0; reg_i = 3'b011;
    chk(!mem_req_o, "R8 wrong register ignored", {31'h0, mem_req_o}, 32'h0);
    repeat (3) @(negedge clk_i);
    chk(!done_o && exp_q.size() == 0, "R8 no result from ignored start",
        {31'h0, done_o}, 32'h0);

    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule